// File: doc/BRIEF.md
# Serial-Input DAC Register Front End

This block is the digital front end of a 12-bit voltage-output converter. A host drives a serial data line, a serial clock, an active-low chip select, an active-low load strobe and an active-low clear. A fast system clock samples every one of these pins. The block keeps two separate storage stages: an input shift register that collects the serial word, and a DAC register that holds the code the converter presents.

A new word can be shifted in while the output keeps its old value. The load strobe then moves the word across. The strobe acts as a level-sensitive latch: while it is low, the DAC register follows the shift register. When it rises, the register keeps what it holds. The clear pin forces the DAC register to zero at once, without waiting for a clock edge.

The block presents the DAC register code and a millivolt value derived from it at one millivolt per code step. The analog reference, resistor ladder and output amplifier are outside this block.

Top module: `serdac_front`

## Requirements
- R1: The shift register advances one bit when a rising edge of the serial clock arrives while chip select is low. The data line enters at bit 0, so the first bit shifted ends up as the most significant bit of the word, in natural binary. The outputs reflect a pin change within eight system clock cycles.
- R2: A rising edge of chip select while the serial clock is low also advances the shift register by one bit. Serial clock edges while chip select is high do not change the shift register.
- R3: When more than 12 bits are shifted, the earliest bits are discarded. The last 12 bits shifted form the word.
- R4: While the load strobe is high, the DAC register keeps its value. Shifting a new word does not change `code_o`.
- R5: While the load strobe is low and clear is high, the DAC register follows the shift register. On the rising edge of the load strobe, the register keeps the value it held last.
- R6: While clear is low, `code_o` and `mv_o` are zero with no clock edge needed, whatever the load strobe does. Clear does not alter the shift register.
- R7: When clear is released while the load strobe is high, the DAC register stays at zero until the load strobe next goes low.
- R8: `mv_o` equals `code_o` times one millivolt per code: code 0x000 gives 0, 0x800 gives 2048, 0xFFF gives 4095.
- R9: `viol_o` is set when a shift happens while the load strobe is low, and it stays set until reset.
- R10: Synchronous reset clears the shift register, the DAC register, `mv_o` and `viol_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| sdin_i | input | 1 | Serial data line |
| sclk_i | input | 1 | Serial clock |
| csn_i | input | 1 | Chip select, active low |
| loadn_i | input | 1 | Load strobe, active low, level-sensitive |
| clrn_i | input | 1 | Clear, active low, asynchronous on the DAC register |
| code_o | output | 12 | DAC register code |
| mv_o | output | 13 | Output value in millivolts |
| viol_o | output | 1 | Sticky flag: a shift happened while the load strobe was low |

## Verification
The assertions assume the following about the inputs:
- Each pin level lasts several system clock cycles, so the two-flop synchronizers see every level and every edge.
- Clear pulses are long enough that the synchronized copy of clear agrees with the raw pin around each check.

The stimulus meets these assumptions:
- It holds every serial clock phase, chip-select phase, strobe pulse and clear pulse for at least four system cycles.
- It changes data only while the serial clock is low.
- At the end of a transfer clocked by the serial clock, it raises chip select while the serial clock is still high. This avoids an unintended extra shift.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int PIN_COUNT = 5;
  localparam int PIN_SDIN  = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_CSN   = 2;
  localparam int PIN_LOADN = 3;
  localparam int PIN_CLRN  = 4;
  // idle levels: selects, strobe and clear high; clock and data low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 5'b11100;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int N = 5,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdin_s,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              loadn_s,
  output logic [DATA_W-1:0] word_o,
  output logic              viol_o
);
  logic sclk_q, csn_q;
  logic sclk_rise, csn_rise, adv;
  logic [DATA_W-1:0] word_q;
  logic viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign csn_rise  = csn_s & ~csn_q;
  // clock and select are interchangeable gates
  assign adv = (sclk_rise & ~csn_s) | (csn_rise & ~sclk_s);

  always_ff @(posedge clk) begin
    if (rst)      word_q <= '0;
    else if (adv) word_q <= {word_q[DATA_W-2:0], sdin_s};
  end

  always_ff @(posedge clk) begin
    if (rst)                 viol_q <= 1'b0;
    else if (adv && !loadn_s) viol_q <= 1'b1;
  end

  assign word_o = word_q;
  assign viol_o = viol_q;

  // R2: select held high with no select edge leaves the word alone
  p_cs_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (csn_s && csn_q) |=> $stable(word_q));
  // R9: a shift during an open strobe raises the flag
  p_viol_set_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !loadn_s) |=> viol_q);
endmodule

// File: rtl/serdac_holdreg.sv
module serdac_holdreg #(
  parameter int DATA_W = 12,
  parameter int MV_PER_CODE = 1,
  localparam int MV_W = DATA_W + $clog2(MV_PER_CODE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clrn_async,
  input  logic              clrn_s,
  input  logic              loadn_s,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] code_o,
  output logic [MV_W-1:0]   mv_o
);
  logic [DATA_W-1:0] code_q;
  logic [MV_W-1:0]   mv_q;

  always_ff @(posedge clk or negedge clrn_async) begin
    if (!clrn_async)            code_q <= '0;
    else if (rst)               code_q <= '0;
    else if (!loadn_s && clrn_s) code_q <= word_i;
  end

  always_ff @(posedge clk or negedge clrn_async) begin
    if (!clrn_async) mv_q <= '0;
    else if (rst)    mv_q <= '0;
    else             mv_q <= MV_W'(code_q) * MV_W'(MV_PER_CODE);
  end

  assign code_o = code_q;
  assign mv_o   = mv_q;

  // R6: clear low means zero code
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !clrn_async |-> (code_q == '0 && mv_q == '0));
  // R4: closed strobe holds the register
  p_latched_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (loadn_s && clrn_async && $past(clrn_async) && !$past(rst))
      |-> code_q == $past(code_q));
  // R8: millivolt output tracks code one cycle later
  p_mv_scale_r8: assert property (@(posedge clk) disable iff (rst)
    (clrn_async && $past(clrn_async) && !$past(rst))
      |-> mv_q == MV_W'($past(code_q)) * MV_W'(MV_PER_CODE));
endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
  parameter int DATA_W = 12,
  parameter int MV_PER_CODE = 1,
  parameter int SYNC_STAGES = 2,
  localparam int MV_W = DATA_W + $clog2(MV_PER_CODE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdin_i,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              loadn_i,
  input  logic              clrn_i,
  output logic [DATA_W-1:0] code_o,
  output logic [MV_W-1:0]   mv_o,
  output logic              viol_o
);
  import serdac_pkg::*;

  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic [DATA_W-1:0]    word;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SDIN]  = sdin_i;
    pins_raw[PIN_SCLK]  = sclk_i;
    pins_raw[PIN_CSN]   = csn_i;
    pins_raw[PIN_LOADN] = loadn_i;
    pins_raw[PIN_CLRN]  = clrn_i;
  end

  serdac_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .async_i(pins_raw), .sync_o(pins_s));

  serdac_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst),
    .sdin_s(pins_s[PIN_SDIN]), .sclk_s(pins_s[PIN_SCLK]),
    .csn_s(pins_s[PIN_CSN]), .loadn_s(pins_s[PIN_LOADN]),
    .word_o(word), .viol_o(viol_o));

  serdac_holdreg #(.DATA_W(DATA_W), .MV_PER_CODE(MV_PER_CODE)) u_hold (
    .clk(clk), .rst(rst), .clrn_async(clrn_i),
    .clrn_s(pins_s[PIN_CLRN]), .loadn_s(pins_s[PIN_LOADN]),
    .word_i(word), .code_o(code_o), .mv_o(mv_o));
endmodule

// File: tb/serdac_front_bench.sv
`timescale 1ns/1ps
module serdac_front_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdin = 1'b0, sclk = 1'b0, csn = 1'b1, loadn = 1'b1, clrn = 1'b1;
  logic [11:0] code;
  logic [12:0] mv;
  logic viol;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  string q_tag[$];
  int    q_code[$];
  bit    q_viol[$];

  always #4 clk = ~clk;

  serdac_front u_serdac_front (
    .clk(clk), .rst(rst), .sdin_i(sdin), .sclk_i(sclk), .csn_i(csn),
    .loadn_i(loadn), .clrn_i(clrn), .code_o(code), .mv_o(mv), .viol_o(viol));

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      string t; int c; bit v;
      wait (q_tag.size() > 0);
      #1;
      t = q_tag.pop_front(); c = q_code.pop_front(); v = q_viol.pop_front();
      checks++;
      if (code !== 12'(c) || mv !== 13'(c) || viol !== v) begin
        failures++;
        $display("FAIL %s: code=%0h mv=%0d viol=%0b expected code=%0h mv=%0d viol=%0b",
                 t, code, mv, viol, c, c, v);
      end
    end
  end

  task automatic expect_out(input string tag, input int c, input bit v);
    q_tag.push_back(tag); q_code.push_back(c); q_viol.push_back(v);
    wait (q_tag.size() == 0);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_bit(input logic b);
    sdin = b; sclk = 1'b0; idle(4);
    sclk = 1'b1; idle(4);
  endtask

  task automatic shift_word(input logic [31:0] val, input int nbits);
    csn = 1'b0; idle(4);
    for (int i = nbits - 1; i >= 0; i--) sclk_bit(val[i]);
    csn = 1'b1; idle(4);   // raised while clock still high
    sclk = 1'b0; idle(4);
  endtask

  task automatic cs_word(input logic [31:0] val, input int nbits);
    sclk = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdin = val[i]; csn = 1'b0; idle(4);
      csn = 1'b1; idle(4);
    end
  endtask

  task automatic pulse_load;
    loadn = 1'b0; idle(6);
    loadn = 1'b1; idle(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(5); rst = 1'b0; idle(2);
    expect_out("R10 reset state", 0, 0);

    shift_word(32'hA5C, 12); idle(8);
    expect_out("R4 preload does not disturb output", 0, 0);
    pulse_load;
    expect_out("R1 msb-first word loaded", 12'hA5C, 0);

    shift_word(32'h800, 12); pulse_load;
    expect_out("R8 midscale 2048 mV", 12'h800, 0);
    shift_word(32'hFFF, 12); pulse_load;
    expect_out("R8 full scale 4095 mV", 12'hFFF, 0);

    shift_word(32'hBEEF, 16); pulse_load;
    expect_out("R3 last 12 bits kept", 12'hEEF, 0);

    cs_word(32'h3C6, 12); pulse_load;
    expect_out("R2 select edges shift", 12'h3C6, 0);

    csn = 1'b1;
    for (int i = 0; i < 12; i++) sclk_bit(1'b1);
    sclk = 1'b0; idle(4);
    pulse_load;
    expect_out("R2 clock ignored while deselected", 12'h3C6, 0);

    @(negedge clk); clrn = 1'b0;
    expect_out("R6 asynchronous clear", 0, 0);
    idle(6); clrn = 1'b1; idle(8);
    expect_out("R7 stays zero after release", 0, 0);
    pulse_load;
    expect_out("R6 shift register untouched by clear", 12'h3C6, 0);

    loadn = 1'b0; idle(6);
    clrn = 1'b0; idle(6);
    expect_out("R6 clear dominates open strobe", 0, 0);
    clrn = 1'b1; idle(8);
    expect_out("R5 transparent after clear release", 12'h3C6, 0);

    shift_word(32'h5A1, 12); idle(8);
    expect_out("R5 R9 follows word, flag set", 12'h5A1, 1);
    loadn = 1'b1; idle(6);
    shift_word(32'h123, 12); idle(8);
    expect_out("R5 R9 latched on strobe rise, flag sticky", 12'h5A1, 1);

    shift_word(32'h000, 12); pulse_load;
    expect_out("R8 zero code 0 mV", 0, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule